// File: doc/BRIEF.md
# Recursive Low-Pass Filter, Fixed Point, Twelve Taps

This block is a single-channel recursive (infinite impulse response) filter built in direct form I. It keeps one shift register of the last eleven accepted input samples and a second one of the last eleven produced output samples. For every accepted sample it forms one new output from both histories with a fixed set of integer coefficients. Samples are signed two's-complement words with 8 fractional bits. The coefficients are real values, rounded at elaboration to the same 8-fractional-bit scale. The feedforward set is a symmetric smoothing kernel. The feedback set has only even-index terms that are large enough to survive rounding.

Both ends are valid/ready streams. A word moves when valid and ready are both high at a rising clock edge. A producer must hold `in_data` steady while `in_valid` waits for `in_ready`. While `out_ready` is low, a presented output does not change. Internally there are two register stages: an input holding register and the output register. When the output is stalled, the block buffers at most one further sample and then drops `in_ready`. Both histories advance only when a sample moves from the input stage into the output register, so idle cycles and stalls do not disturb the recursion.

Top module: `iir_df1`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0. Reset clears both sample histories, so the first outputs after reset are those of a filter whose earlier inputs and outputs are all zero.
- R2: The integer coefficients are round(c*256). Feedforward b0..b11 = 0, 5, 23, 68, 137, 191, 191, 137, 68, 23, 5, 0. Feedback a1..a11 = 0, 379, 0, 180, 0, 32, 0, 2, 0, 0, 0. a0 is implicit.
- R3: For the n-th accepted sample x[n], the output is y[n] = sum over k=0..11 of b_k*x[n-k], minus sum over k=1..11 of a_k*y[n-k]. It is computed at full precision. Outputs leave in acceptance order, one per accepted sample.
- R4: Requantization: the result is ((acc + 128) >>> 8) with arithmetic shift, keeping the low 32 bits in two's complement (wrap-around, no saturation).
- R5: With `out_ready` high and the block empty, a sample accepted at edge k is presented with `out_valid` high after edge k+1, and not before.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R7: `in_ready` is high whenever `out_valid` is low. With the output stalled and one sample buffered, `in_ready` is low.
- R8: Cycles where `in_valid` is low or no transfer occurs leave the result sequence unchanged: outputs depend only on the sequence of accepted samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_data | input | 32 | Input sample, signed, 8 fractional bits |
| out_valid | output | 1 | Output sample presented |
| out_ready | input | 1 | Consumer takes the output this cycle |
| out_data | output | 32 | Filtered sample, signed, 8 fractional bits |

## Verification
Positive and negative unit impulses after a reset expose the quantized feedforward taps and the first feedback term. Their leading values come from hand arithmetic, and the negative impulse shows the rounding direction. Long random runs use small-magnitude samples to check the recursion over many feedback steps. Full-range samples exercise the 32-bit wrap. Random gaps on `in_valid` and random stalls on `out_ready` separate sequence-dependent behaviour from timing-dependent behaviour. A directed stall and a single-sample latency probe pin down the buffering limit and the two-stage timing.

// File: rtl/iir_pkg.sv
package iir_pkg;
  localparam int TAPS   = 12;
  localparam int DATA_W = 32;
  localparam int FRAC   = 8;
  localparam int COEF_W = 16;
  localparam int HIST   = TAPS - 1;

  // real feedforward value, symmetric about the centre
  function automatic real ff_real(input int k);
    int m;
    m = (k < TAPS / 2) ? k : TAPS - 1 - k;
    case (m)
      0:       return 0.001618571;
      1:       return 0.01780428;
      2:       return 0.08902138;
      3:       return 0.2670642;
      4:       return 0.5341283;
      5:       return 0.7477796;
      default: return 0.0;
    endcase
  endfunction

  // real feedback value; odd terms are tiny and round to zero
  function automatic real fb_real(input int k);
    case (k)
      0:       return 1.0;
      1:       return 8.274631e-16;
      2:       return 1.479294;
      3:       return 1.089388e-15;
      4:       return 0.7013122;
      5:       return 4.861197e-16;
      6:       return 0.1262132;
      7:       return 9.512539e-17;
      8:       return 0.007898376;
      9:       return -4.496047e-18;
      10:      return 0.0001152699;
      11:      return -6.398766e-21;
      default: return 0.0;
    endcase
  endfunction

  function automatic int quantize(input real r);
    return int'(r * real'(1 << FRAC));
  endfunction
endpackage

// File: rtl/iir_stage.sv
module iir_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  assign up_ready = !dn_valid || dn_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      dn_data  <= '0;
    end else if (up_ready) begin
      dn_valid <= up_valid;
      if (up_valid) dn_data <= up_data;
    end
  end
endmodule

// File: rtl/iir_delay_line.sv
module iir_delay_line #(
  parameter int W     = 32,
  parameter int DEPTH = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift,
  input  logic signed [W-1:0] din,
  output logic signed [W-1:0] taps [DEPTH]
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic signed [W-1:0] src;
    if (i == 0) begin : g_head
      assign src = din;
    end else begin : g_body
      assign src = taps[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     taps[i] <= '0;
      else if (shift) taps[i] <= src;
    end
  end
endmodule

// File: rtl/iir_mac.sv
module iir_mac
  import iir_pkg::*;
(
  input  logic signed [DATA_W-1:0] x_cur,
  input  logic signed [DATA_W-1:0] x_taps [HIST],
  input  logic signed [DATA_W-1:0] y_taps [HIST],
  output logic signed [DATA_W-1:0] y_next
);
  localparam int NPROD = TAPS + HIST;
  localparam int ACC_W = DATA_W + COEF_W + $clog2(NPROD);
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1 << (FRAC - 1));

  logic signed [ACC_W-1:0] prod [NPROD];
  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] rounded;
  logic signed [ACC_W-1:0] shifted;

  for (genvar k = 0; k < TAPS; k++) begin : g_ff
    localparam logic signed [COEF_W-1:0] CB = COEF_W'(quantize(ff_real(k)));
    logic signed [DATA_W-1:0] xs;
    if (k == 0) begin : g_now
      assign xs = x_cur;
    end else begin : g_old
      assign xs = x_taps[k-1];
    end
    assign prod[k] = ACC_W'(xs) * ACC_W'(CB);
  end

  for (genvar k = 1; k < TAPS; k++) begin : g_fb
    localparam logic signed [COEF_W-1:0] CA = COEF_W'(quantize(fb_real(k)));
    assign prod[TAPS+k-1] = -(ACC_W'(y_taps[k-1]) * ACC_W'(CA));
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < NPROD; i++) acc = acc + prod[i];
    rounded = acc + HALF;
    shifted = rounded >>> FRAC;
    y_next  = shifted[DATA_W-1:0];
  end
endmodule

// File: rtl/iir_df1.sv
module iir_df1
  import iir_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  logic              s1_valid;
  logic [DATA_W-1:0] s1_data;
  logic              s2_ready;
  logic              advance;
  logic signed [DATA_W-1:0] x_hist [HIST];
  logic signed [DATA_W-1:0] y_hist [HIST];
  logic signed [DATA_W-1:0] y_new;

  iir_stage #(.W(DATA_W)) u_in (
    .clk(clk), .rst_n(rst_n),
    .up_valid(in_valid), .up_ready(in_ready), .up_data(in_data),
    .dn_valid(s1_valid), .dn_ready(s2_ready), .dn_data(s1_data)
  );

  iir_mac u_mac (
    .x_cur(s1_data), .x_taps(x_hist), .y_taps(y_hist), .y_next(y_new)
  );

  iir_stage #(.W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .up_valid(s1_valid), .up_ready(s2_ready), .up_data(y_new),
    .dn_valid(out_valid), .dn_ready(out_ready), .dn_data(out_data)
  );

  assign advance = s1_valid && s2_ready;

  iir_delay_line #(.W(DATA_W), .DEPTH(HIST)) u_xline (
    .clk(clk), .rst_n(rst_n), .shift(advance), .din(s1_data), .taps(x_hist)
  );

  iir_delay_line #(.W(DATA_W), .DEPTH(HIST)) u_yline (
    .clk(clk), .rst_n(rst_n), .shift(advance), .din(y_new), .taps(y_hist)
  );
endmodule

// File: rtl/iir_df1_chk.sv
module iir_df1_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data
);
  always @(posedge clk) begin
    if (!rst_n) AST_RESET_IDLE: assert (!out_valid); // R1
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R6

  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R7

  AST_TWO_STAGE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready, 2)); // R5
endmodule

bind iir_df1 iir_df1_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/iir_df1_test.sv
module iir_df1_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;

  int checks = 0;
  int errors = 0;

  // R2 coefficients, written out from the requirement
  int bq [12] = '{0, 5, 23, 68, 137, 191, 191, 137, 68, 23, 5, 0};
  int aq [12] = '{256, 0, 379, 0, 180, 0, 32, 0, 2, 0, 0, 0};
  longint xm [12];
  longint ym [12];
  int exp_q [$];

  always #4 clk = ~clk;

  iir_df1 uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  function automatic void model_clear();
    for (int k = 0; k < 12; k++) begin xm[k] = 0; ym[k] = 0; end
  endfunction

  // R3/R4 reference recursion
  function automatic int model_step(input logic [31:0] x);
    longint acc;
    longint r;
    for (int k = 11; k > 0; k--) xm[k] = xm[k-1];
    xm[0] = longint'($signed(x));
    acc = 0;
    for (int k = 0; k < 12; k++) acc += bq[k] * xm[k];
    for (int k = 1; k < 12; k++) acc -= aq[k] * ym[k];
    r = (acc + 128) >>> 8;
    for (int k = 11; k > 1; k--) ym[k] = ym[k-1];
    ym[1] = longint'($signed(r[31:0]));
    return int'(r[31:0]);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input logic v, input logic [31:0] d, input logic r);
    int e;
    @(negedge clk);
    in_valid = v; in_data = d; out_ready = r;
    #1;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) check(1'b0, "R3 unexpected output", $signed(out_data), 0);
      else begin
        e = exp_q.pop_front();
        check($signed(out_data) == e, "R3/R8 output sequence", $signed(out_data), e);
      end
    end
    if (in_valid && in_ready) exp_q.push_back(model_step(in_data));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    #1;
    check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    exp_q.delete();
    model_clear();
    rst_n = 1'b1;
  endtask

  task automatic drain();
    repeat (4) tick(1'b0, '0, 1'b1);
  endtask

  // R2/R4 impulse of +/-1.0; positions: with continuous flow, tick t shows y[t-3]
  task automatic impulse(input int sgn);
    int exp_v [4];
    exp_v = '{0, 5 * sgn, 23 * sgn, (sgn > 0) ? 61 : -61};
    if (sgn < 0) begin
      exp_v[1] = -5; exp_v[2] = -23;
      // -(15513) + 128 = -15385 ; floor(/256) = -61
    end
    tick(1'b1, 32'(256 * sgn), 1'b1);
    for (int t = 2; t <= 6; t++) begin
      tick(1'b1, '0, 1'b1);
      if (t >= 3) check($signed(out_data) == exp_v[t-3], "R2/R4 impulse tap",
                        $signed(out_data), exp_v[t-3]);
    end
    drain();
  endtask

  initial begin : watchdog
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] held;
    logic [31:0] pend;
    logic        have;
    int          dummy;
    dummy = $urandom(32'h1F2E3D4C);
    model_clear();
    do_reset();

    impulse(1);
    do_reset();
    impulse(-1);

    // R5: single sample latency
    tick(1'b1, 32'd1000, 1'b1);
    tick(1'b0, '0, 1'b1);
    check(out_valid == 1'b0, "R5 not before edge k+1", out_valid, 0);
    tick(1'b0, '0, 1'b1);
    check(out_valid == 1'b1, "R5 present after edge k+1", out_valid, 1);
    drain();

    // R6/R7: stall with one buffered sample
    tick(1'b1, 32'd512, 1'b0);
    tick(1'b1, 32'd768, 1'b0);
    check(in_ready == 1'b1, "R7 ready while output empty", in_ready, 1);
    tick(1'b1, 32'hFFFF_FF00, 1'b0);
    check(in_ready == 1'b0, "R7 ready low when full", in_ready, 0);
    held = out_data;
    for (int i = 0; i < 3; i++) begin
      tick(1'b1, 32'hFFFF_FF00, 1'b0);
      check(out_valid && out_data == held, "R6 output held in stall", $signed(out_data), $signed(held));
      check(in_ready == 1'b0, "R7 ready stays low", in_ready, 0);
    end
    tick(1'b1, 32'hFFFF_FF00, 1'b1);
    drain();

    // R3/R8: random traffic with gaps and stalls
    have = 1'b0; pend = '0;
    for (int n = 0; n < 3000; n++) begin
      logic v;
      if (!have && ($urandom % 4 != 0)) begin
        have = 1'b1;
        if (n < 2000) pend = 32'($signed(($urandom % 20001)) - 10000);
        else          pend = $urandom;
      end
      v = have;
      tick(v, pend, ($urandom % 3) != 0);
      if (in_valid && in_ready) have = 1'b0;
    end
    drain();
    check(exp_q.size() == 0, "R3 one output per sample", exp_q.size(), 0);

    // R1: reset clears history mid-stream
    for (int i = 0; i < 8; i++) tick(1'b1, $urandom, 1'b1);
    do_reset();
    impulse(1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule